// File: doc/BRIEF.md
# Host-to-Device Stream Packetizer

This block turns memory read data into AXI4-Stream packets toward the device. It takes one data descriptor at a time from an upstream fetcher. Each descriptor carries a byte length, a software-assigned index, and two framing flags: one opens a packet and one closes it. The payload bytes arrive in order from a 256-bit memory read port. The block forwards them as stream beats. On the last beat of each descriptor it trims `tkeep` to the payload length. It raises `tlast` only where the descriptor's close flag asks for it, so one stream packet can span any number of descriptors.

When the last beat of a descriptor has been accepted downstream, the block writes that descriptor's index into a completed-pointer output and pulses a strobe. Software starts numbering at 1, so a pointer of zero means that nothing has completed yet. A length field of zero stands for the largest transfer, 1,048,576 bytes. If a descriptor that does not open a packet arrives while no packet is open, the block sets a sticky error flag and still forwards the data.

Top module: `h2d_stream_packetizer`

## Requirements
- R1: After reset, `m_tvalid`, `cmpl_strobe` and `err_no_sof` are 0, `cmpl_ptr` is 0 and `desc_ready` is 1.
- R2: A descriptor of L bytes (1 to 1,048,575) produces ceil(L/32) output beats. Their `m_tdata` words are the read-port words in arrival order.
- R3: A length field of 0 is treated as 1,048,576 bytes, which is 32768 full beats.
- R4: Every beat that is not a descriptor's final beat has all 32 `m_tkeep` bits set. On the final beat, bit i (lane i is `m_tdata[8i+7:8i]`) is set exactly when i is less than the bytes that remain.
- R5: `m_tlast` is 1 only on the final beat of a descriptor whose `desc_eof` is 1. A descriptor with both `desc_sof` and `desc_eof` set forms a packet on its own.
- R6: Descriptors with neither flag that follow an opened packet continue it. None of their beats carries `m_tlast`.
- R7: In the cycle after a descriptor's final beat is accepted (`m_tvalid && m_tready`), `cmpl_strobe` is 1 for one cycle and `cmpl_ptr` equals that descriptor's `desc_idx`. `cmpl_ptr` holds its value until the next completion.
- R8: While `m_tready` is 0, `m_tvalid`, `m_tdata`, `m_tkeep` and `m_tlast` hold. Across any pattern of stalls on `m_tready` and `rd_valid`, no beat is lost or repeated.
- R9: Accepting a descriptor with `desc_sof`=0 while no packet is open sets `err_no_sof`. The flag stays set until reset, and that descriptor's data is still forwarded. A descriptor without `desc_sof` inside an open packet leaves the flag unchanged.
- R10: Only one descriptor is in progress at a time. `desc_ready` is 1 only when no descriptor is in progress, and `rd_ready` is 0 whenever `desc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor taken on this cycle when valid |
| desc_len | input | 20 | Payload bytes, 0 means 1 MB |
| desc_idx | input | 16 | Software index of the descriptor |
| desc_sof | input | 1 | Descriptor opens a packet |
| desc_eof | input | 1 | Descriptor closes the packet |
| rd_valid | input | 1 | Read data word present |
| rd_ready | output | 1 | Read data word consumed |
| rd_data | input | 256 | Read data word |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 256 | Stream data |
| m_tkeep | output | 32 | Byte lane enables |
| m_tlast | output | 1 | Packet end |
| cmpl_ptr | output | 16 | Index of the last completed descriptor |
| cmpl_strobe | output | 1 | One-cycle pulse when `cmpl_ptr` is written |
| err_no_sof | output | 1 | Sticky: data descriptor arrived with no open packet |

## Verification
The bench targets the final-beat arithmetic. It uses lengths one byte above and below a beat boundary, exact multiples of 32, a one-byte descriptor and the zero-length case. A design that got these wrong would emit an extra or a missing beat, or trim `tkeep` by one lane.

Multi-descriptor packets run under irregular stalls on both `m_tready` and `rd_valid`. A faulty framing tracker would put `tlast` on the wrong descriptor. A faulty stall path would repeat or drop a word, which breaks the in-order data match.

The bench also checks the following:
- Completions must arrive one cycle after the final handshake, with the right index.
- A descriptor without a start flag must raise the error only outside an open packet.
- The error must survive later good traffic.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } hsp_state_t;

  typedef struct packed {
    logic opens;
    logic closes;
  } hsp_flags_t;
endpackage

// File: rtl/hsp_desc_track.sv
module hsp_desc_track #(
  parameter int LEN_W = 20,
  parameter int IDX_W = 16,
  parameter int BYTES = 32,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [LEN_W-1:0] desc_len,
  input  logic [IDX_W-1:0] desc_idx,
  input  logic             desc_sof,
  input  logic             desc_eof,
  input  logic             beat_take,
  output logic             busy,
  output logic [CNT_W-1:0] rem_bytes,
  output logic             last_beat,
  output logic             cur_eof,
  output logic [IDX_W-1:0] cur_idx,
  output logic             err
);
  import hsp_pkg::*;

  localparam logic [CNT_W-1:0] MAX_BYTES  = CNT_W'(1) << LEN_W;
  localparam logic [CNT_W-1:0] BEAT_BYTES = CNT_W'(BYTES);

  hsp_state_t       state_q;
  hsp_flags_t       flags_q;
  logic [CNT_W-1:0] rem_q;
  logic [IDX_W-1:0] idx_q;
  logic             open_q;
  logic             err_q;
  logic             accept;

  assign desc_ready = (state_q == ST_IDLE);
  assign accept     = desc_valid && desc_ready;
  assign busy       = (state_q == ST_BUSY);
  assign last_beat  = (rem_q <= BEAT_BYTES);
  assign rem_bytes  = rem_q;
  assign cur_eof    = flags_q.closes;
  assign cur_idx    = idx_q;
  assign err        = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      flags_q <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      open_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      state_q        <= ST_BUSY;
      rem_q          <= (desc_len == '0) ? MAX_BYTES : {1'b0, desc_len};
      idx_q          <= desc_idx;
      flags_q.opens  <= desc_sof;
      flags_q.closes <= desc_eof;
      open_q         <= 1'b1;
      if (!desc_sof && !open_q) err_q <= 1'b1;
    end else if (beat_take) begin
      if (last_beat) begin
        state_q <= ST_IDLE;
        rem_q   <= '0;
        if (flags_q.closes) open_q <= 1'b0;
      end else begin
        rem_q <= rem_q - BEAT_BYTES;
      end
    end
  end
endmodule

// File: rtl/hsp_keep_gen.sv
module hsp_keep_gen #(
  parameter int BYTES = 32,
  parameter int CNT_W = 21
) (
  input  logic [CNT_W-1:0] rem_bytes,
  input  logic             last_beat,
  output logic [BYTES-1:0] keep
);
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign keep[i] = !last_beat || (rem_bytes > CNT_W'(i));
  end
endmodule

// File: rtl/hsp_out_stage.sv
module hsp_out_stage #(
  parameter int DATA_W = 256,
  parameter int BYTES  = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BYTES-1:0]  in_keep,
  input  logic              in_last,
  input  logic              in_final,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic              tready,
  output logic              can_load,
  output logic              tvalid,
  output logic [DATA_W-1:0] tdata,
  output logic [BYTES-1:0]  tkeep,
  output logic              tlast,
  output logic [IDX_W-1:0]  cmpl_ptr,
  output logic              cmpl_strobe
);
  logic             valid_q;
  logic             final_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_hs;

  assign can_load = !valid_q || tready;
  assign tvalid   = valid_q;
  assign done_hs  = valid_q && tready && final_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= 1'b0;
      tdata       <= '0;
      tkeep       <= '0;
      tlast       <= 1'b0;
      final_q     <= 1'b0;
      idx_q       <= '0;
      cmpl_ptr    <= '0;
      cmpl_strobe <= 1'b0;
    end else begin
      cmpl_strobe <= done_hs;
      if (done_hs) cmpl_ptr <= idx_q;
      if (load) begin
        valid_q <= 1'b1;
        tdata   <= in_data;
        tkeep   <= in_keep;
        tlast   <= in_last;
        final_q <= in_final;
        idx_q   <= in_idx;
      end else if (tready) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/h2d_stream_packetizer.sv
module h2d_stream_packetizer #(
  parameter int DATA_W = 256,
  parameter int LEN_W  = 20,
  parameter int IDX_W  = 16,
  localparam int BYTES = DATA_W / 8,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic [IDX_W-1:0]  desc_idx,
  input  logic              desc_sof,
  input  logic              desc_eof,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [BYTES-1:0]  m_tkeep,
  output logic              m_tlast,
  output logic [IDX_W-1:0]  cmpl_ptr,
  output logic              cmpl_strobe,
  output logic              err_no_sof
);
  logic             busy;
  logic [CNT_W-1:0] rem_bytes;
  logic             last_beat;
  logic             cur_eof;
  logic [IDX_W-1:0] cur_idx;
  logic             can_load;
  logic             beat_take;
  logic [BYTES-1:0] beat_keep;

  assign rd_ready  = busy && can_load;
  assign beat_take = rd_valid && rd_ready;

  hsp_desc_track #(.LEN_W(LEN_W), .IDX_W(IDX_W), .BYTES(BYTES)) u_track (
    .clk(clk), .rst(rst),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_len(desc_len), .desc_idx(desc_idx),
    .desc_sof(desc_sof), .desc_eof(desc_eof),
    .beat_take(beat_take), .busy(busy),
    .rem_bytes(rem_bytes), .last_beat(last_beat),
    .cur_eof(cur_eof), .cur_idx(cur_idx), .err(err_no_sof)
  );

  hsp_keep_gen #(.BYTES(BYTES), .CNT_W(CNT_W)) u_keep (
    .rem_bytes(rem_bytes), .last_beat(last_beat), .keep(beat_keep)
  );

  hsp_out_stage #(.DATA_W(DATA_W), .BYTES(BYTES), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst(rst),
    .load(beat_take), .in_data(rd_data), .in_keep(beat_keep),
    .in_last(last_beat && cur_eof), .in_final(last_beat), .in_idx(cur_idx),
    .tready(m_tready), .can_load(can_load),
    .tvalid(m_tvalid), .tdata(m_tdata), .tkeep(m_tkeep), .tlast(m_tlast),
    .cmpl_ptr(cmpl_ptr), .cmpl_strobe(cmpl_strobe)
  );
endmodule

// File: rtl/hsp_checker.sv
module hsp_checker #(
  parameter int DATA_W = 256,
  parameter int BYTES  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              desc_ready,
  input logic              rd_ready,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic [BYTES-1:0]  m_tkeep,
  input logic              m_tlast,
  input logic              cmpl_strobe,
  input logic              err_no_sof
);
  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast));

  a_r4_keep_low_mask: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (m_tkeep != '0) && (((m_tkeep + BYTES'(1)) & m_tkeep) == '0));

  a_r7_cmpl_after_handshake: assert property (@(posedge clk) disable iff (rst)
    cmpl_strobe |-> $past(m_tvalid && m_tready));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_no_sof |=> err_no_sof);

  a_r10_no_read_when_idle: assert property (@(posedge clk) disable iff (rst)
    desc_ready |-> !rd_ready);
endmodule

bind h2d_stream_packetizer hsp_checker #(.DATA_W(DATA_W), .BYTES(BYTES)) u_chk (
  .clk(clk), .rst(rst), .desc_ready(desc_ready), .rd_ready(rd_ready),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
  .m_tkeep(m_tkeep), .m_tlast(m_tlast), .cmpl_strobe(cmpl_strobe),
  .err_no_sof(err_no_sof)
);

// File: tb/h2d_stream_packetizer_test.sv
`timescale 1ns/1ps
module h2d_stream_packetizer_test;
  localparam int DATA_W = 256;
  localparam int LEN_W  = 20;
  localparam int IDX_W  = 16;
  localparam int BYTES  = 32;
  localparam int MEM_D  = 64;
  localparam int NVEC   = 8;

  typedef struct packed {
    logic [19:0] len;
    logic [15:0] idx;
    logic        sof;
    logic        eof;
  } vec_t;

  // length, index, open flag, close flag; beats and tkeep/tlast follow from them
  localparam vec_t VECS [NVEC] = '{
    '{20'd100, 16'd1, 1'b1, 1'b1},
    '{20'd32,  16'd2, 1'b1, 1'b0},
    '{20'd64,  16'd3, 1'b0, 1'b0},
    '{20'd33,  16'd4, 1'b0, 1'b1},
    '{20'd1,   16'd5, 1'b1, 1'b1},
    '{20'd31,  16'd6, 1'b1, 1'b1},
    '{20'd95,  16'd7, 1'b1, 1'b0},
    '{20'd96,  16'd8, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst;
  logic              desc_valid, desc_ready;
  logic [LEN_W-1:0]  desc_len;
  logic [IDX_W-1:0]  desc_idx;
  logic              desc_sof, desc_eof;
  logic              rd_valid, rd_ready;
  logic [DATA_W-1:0] rd_data;
  logic              m_tvalid, m_tready, m_tlast;
  logic [DATA_W-1:0] m_tdata;
  logic [BYTES-1:0]  m_tkeep;
  logic [IDX_W-1:0]  cmpl_ptr;
  logic              cmpl_strobe, err_no_sof;

  h2d_stream_packetizer uut (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_len(desc_len), .desc_idx(desc_idx), .desc_sof(desc_sof), .desc_eof(desc_eof),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tlast(m_tlast),
    .cmpl_ptr(cmpl_ptr), .cmpl_strobe(cmpl_strobe), .err_no_sof(err_no_sof)
  );

  logic [DATA_W-1:0] mem [MEM_D];
  int checks = 0, failures = 0;
  int rd_ptr = 0, beat_no = 0, cyc = 0;
  bit stall = 1'b0;

  logic [19:0] exp_len [32];
  logic [15:0] exp_idx [32];
  logic        exp_eof [32];
  int exp_wr = 0, exp_rd = 0, cmp_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // memory model and sink pacing
  initial begin
    for (int k = 0; k < MEM_D; k++) mem[k] = {8{32'(k) * 32'h9E3779B1 + 32'h11}};
    rd_valid = 1'b0; m_tready = 1'b0; rd_data = mem[0];
    forever begin
      bit hs;
      @(negedge clk);
      hs = rd_valid && rd_ready;
      @(posedge clk);
      #1;
      cyc++;
      if (hs) rd_ptr++;
      rd_data  = mem[rd_ptr % MEM_D];
      rd_valid = stall ? ((cyc % 5) != 2) : 1'b1;
      m_tready = stall ? ((cyc % 3) != 0) : 1'b1;
    end
  end

  // output monitor
  initial begin
    int mon_rem = 0;
    bit loaded = 1'b0, pend = 1'b0;
    logic [15:0] pend_idx = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        pend = 1'b0; loaded = 1'b0;
      end else begin
        if (pend) begin
          chk(cmpl_strobe && cmpl_ptr == pend_idx, "R7 completion index",
              {cmpl_strobe, cmpl_ptr}, {1'b1, pend_idx});
          cmp_cnt++;
          pend = 1'b0;
        end else if (cmpl_strobe) begin
          chk(1'b0, "R7 stray completion", cmpl_ptr, 0);
        end
        if (m_tvalid && m_tready) begin
          if (exp_rd >= exp_wr) begin
            chk(1'b0, "R8 unexpected beat", m_tdata, 0);
          end else begin
            bit last;
            logic [31:0] ekeep;
            if (!loaded) begin
              mon_rem = (exp_len[exp_rd] == 0) ? (1 << 20) : int'(exp_len[exp_rd]);
              loaded = 1'b1;
            end
            last  = (mon_rem <= 32);
            ekeep = (last && mon_rem < 32) ? ((32'd1 << mon_rem) - 32'd1) : 32'hFFFF_FFFF;
            chk(m_tdata == mem[beat_no % MEM_D], "R2 data order", m_tdata, mem[beat_no % MEM_D]);
            chk(m_tkeep == ekeep, "R4 tkeep", m_tkeep, ekeep);
            chk(m_tlast == (last && exp_eof[exp_rd]), "R5 R6 tlast", m_tlast, last && exp_eof[exp_rd]);
            beat_no++;
            mon_rem -= 32;
            if (last) begin
              pend = 1'b1; pend_idx = exp_idx[exp_rd];
              loaded = 1'b0; exp_rd++;
            end
          end
        end
      end
    end
  end

  task automatic send(input vec_t v);
    exp_len[exp_wr] = v.len; exp_idx[exp_wr] = v.idx; exp_eof[exp_wr] = v.eof;
    exp_wr++;
    @(posedge clk); #1;
    desc_valid = 1'b1; desc_len = v.len; desc_idx = v.idx; desc_sof = v.sof; desc_eof = v.eof;
    do @(negedge clk); while (!desc_ready);
    @(posedge clk); #1;
    desc_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!(exp_rd == exp_wr && cmp_cnt == exp_wr)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    @(negedge clk);
    chk(!m_tvalid && !cmpl_strobe && !err_no_sof && desc_ready && cmpl_ptr == 0, tag,
        {m_tvalid, cmpl_strobe, err_no_sof, desc_ready, cmpl_ptr}, {4'b0001, 16'h0});
  endtask

  task automatic run_all();
    int total;
    int start;
    rst = 1'b1; desc_valid = 1'b0; desc_len = '0; desc_idx = '0; desc_sof = 1'b0; desc_eof = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    check_reset_state("R1 reset state");

    // table walk under stalls on both sides
    stall = 1'b1;
    total = 0;
    for (int i = 0; i < NVEC; i++) begin
      total += (int'(VECS[i].len) + 31) / 32;
      send(VECS[i]);
    end
    wait_done();
    chk(beat_no == total, "R8 R2 beat count", beat_no, total);
    chk(err_no_sof == 1'b0, "R9 no error inside open packet", err_no_sof, 0);
    chk(desc_ready && !rd_ready, "R10 idle handshake", {desc_ready, rd_ready}, 2'b10);
    chk(cmpl_ptr == 16'd8, "R7 pointer holds", cmpl_ptr, 8);

    // descriptor without start while no packet is open
    start = beat_no;
    send('{20'd32, 16'd9, 1'b0, 1'b1});
    wait_done();
    chk(err_no_sof == 1'b1, "R9 error raised", err_no_sof, 1);
    chk(beat_no == start + 1, "R9 data still forwarded", beat_no, start + 1);

    // zero length means the largest transfer
    stall = 1'b0;
    start = beat_no;
    send('{20'd0, 16'd10, 1'b1, 1'b1});
    wait_done();
    chk(beat_no == start + 32768, "R3 max length beats", beat_no, start + 32768);
    chk(cmpl_ptr == 16'd10, "R3 R7 max completion", cmpl_ptr, 10);
    chk(err_no_sof == 1'b1, "R9 error sticky", err_no_sof, 1);

    // reset clears everything
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    check_reset_state("R1 reset after traffic");
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (180000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule